// File: doc/BRIEF.md
# Execution Trace Capture Controller

This block records a processor's execution history into a small on-chip circular memory so that a debugger can later read back what the core did around a point of interest. An 8-bit control register selects whether tracing is requested, which of four capture policies applies, and whether the external trigger closes or opens the capture window. The other inputs are a stream of retired-instruction events (program counter and change-of-flow flag) and data-access events (address and data), together with arm, trigger and secure levels.

The four policies are:
- **Flow:** keeps only change-of-flow targets.
- **Flow with repeat filtering:** discards an entry that would duplicate the one most recently stored.
- **Access detail:** keeps the address and data of every access.
- **Compact program counter:** keeps the counter of every retired instruction, shortened to its low byte when its upper bits repeat the previous stored counter.

With end alignment, recording starts at arming, wraps over the oldest entries, and stops at the trigger. With start alignment, nothing is kept until the trigger, and recording stops when the memory is full. Writes to the control fields are refused while armed, and the enable field is also locked while secure. The readout port returns data only while tracing is enabled.

Top module: `trc_capture`

## Requirements
- R1: After reset the control register reads 0x00, the entry count is 0 and the readout port returns 0.
- R2: The control register keeps only bit 6 (trace enable), bits 3:2 (capture policy) and bit 0 (alignment); all other bits read as 0 whatever was written.
- R3: A write changes bit 6 only when both secure and arm are low, and changes bits 3:2 and 0 only when arm is low.
- R4: Policy 00 stores one entry per event with ev_valid and ev_cof both high, as {flag 0, ev_pc, data 0}; other events and data accesses are not stored.
- R5: Policy 01 stores entries as in R4, but drops an entry that equals the last entry stored since arming.
- R6: Policy 10 stores one entry {flag 0, mem_addr, mem_data} per cycle with mem_valid high, including repeated identical accesses; instruction events are not stored.
- R7: Policy 11 stores one entry per ev_valid cycle. The entry is {flag 1, low byte of ev_pc zero-extended, data 0} when ev_pc[AW-1:8] equals the upper bits of the last stored counter since arming. Otherwise it is {flag 0, ev_pc, data 0}.
- R8: With bit 0 = 0, storing runs from the cycle after arm rises up to and including the trigger cycle, then stops. Once DEPTH entries exist, each new entry replaces the oldest entry, and the count stays at DEPTH.
- R9: With bit 0 = 1, nothing is stored before the trigger. The event in the trigger cycle is the first entry, and storing stops once DEPTH entries exist.
- R10: While secure is high, no entry is stored, even with bit 6 already set.
- R11: rd_data shows the entry rd_idx places after the oldest stored entry, counting from 0. It shows 0 when bit 6 is clear or when rd_idx is not below the count.
- R12: The cycle in which arm is first seen high clears the stored history, the repeat filter and the compact-counter reference. Contents stay readable after arm falls.
- R13: Entry layout is {flag [AW+DW], address [AW+DW-1:DW], data [DW-1:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write value |
| reg_rdata | output | 8 | Control register read value |
| secure | input | 1 | System secure level |
| arm | input | 1 | Capture session armed |
| trig | input | 1 | Trigger level for the current cycle |
| ev_valid | input | 1 | An instruction retired this cycle |
| ev_pc | input | AW | Counter of the retired instruction or flow target |
| ev_cof | input | 1 | Retired instruction changed the flow |
| mem_valid | input | 1 | A data access completed this cycle |
| mem_addr | input | AW | Access address |
| mem_data | input | DW | Access data |
| rd_idx | input | log2(DEPTH) | Readout index, 0 = oldest |
| rd_data | output | 1+AW+DW | Readout entry |
| entry_count | output | log2(DEPTH)+1 | Number of stored entries |

## Verification
Two pairs of events can fall in the same cycle. The first is a qualifying event and the trigger. The bench drives an instruction event and the trigger in one cycle for both alignments. With end alignment, that entry must be the newest and nothing after it may be stored. With start alignment, it must be the oldest and earlier events must be absent. The second pair is a control write and an armed or secure level: a table of writes, each taken under a chosen secure/arm pair, is judged by reading the register back after each write.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int CTL_W     = 8;
  localparam int SRC_BIT   = 6;
  localparam int MODE_LO   = 2;
  localparam int ALIGN_BIT = 0;
  localparam logic [CTL_W-1:0] CTL_MASK = 8'h4D;

  typedef enum logic [1:0] {
    TM_FLOW   = 2'b00,
    TM_FILTER = 2'b01,
    TM_DETAIL = 2'b10,
    TM_PCCMP  = 2'b11
  } trc_mode_e;

  typedef enum logic [2:0] {
    CS_IDLE = 3'd0,
    CS_HIST = 3'd1,
    CS_WAIT = 3'd2,
    CS_POST = 3'd3,
    CS_DONE = 3'd4
  } cap_st_e;
endpackage

// File: rtl/trc_ctl_reg.sv
module trc_ctl_reg
  import trc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  input  logic             secure,
  input  logic             armed,
  output logic             src_en,
  output trc_mode_e        mode,
  output logic             align,
  output logic [CTL_W-1:0] rdata,
  output logic             src_we,
  output logic             fld_we
);
  logic             src_q;
  logic             align_q;
  trc_mode_e        mode_q;
  logic [CTL_W-1:0] wval;

  function automatic logic [CTL_W-1:0] pack_ctl(input logic s, input trc_mode_e m,
                                                input logic a);
    logic [CTL_W-1:0] r;
    r = '0;
    r[SRC_BIT]       = s;
    r[MODE_LO +: 2]  = m;
    r[ALIGN_BIT]     = a;
    return r;
  endfunction

  assign wval   = wdata & CTL_MASK;
  assign src_we = wr & ~secure & ~armed;
  assign fld_we = wr & ~armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q   <= 1'b0;
      align_q <= 1'b0;
      mode_q  <= TM_FLOW;
    end else begin
      if (src_we) src_q <= wval[SRC_BIT];
      if (fld_we) begin
        mode_q  <= trc_mode_e'(wval[MODE_LO +: 2]);
        align_q <= wval[ALIGN_BIT];
      end
    end
  end

  assign src_en = src_q;
  assign mode   = mode_q;
  assign align  = align_q;
  assign rdata  = pack_ctl(src_q, mode_q, align_q);
endmodule

// File: rtl/trc_entry_sel.sv
module trc_entry_sel
  import trc_pkg::*;
#(
  parameter  int AW = 16,
  parameter  int DW = 8,
  localparam int EW = 1 + AW + DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  trc_mode_e     mode,
  input  logic          ev_valid,
  input  logic [AW-1:0] ev_pc,
  input  logic          ev_cof,
  input  logic          mem_valid,
  input  logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_data,
  input  logic          commit,
  output logic          cand_valid,
  output logic [EW-1:0] cand_entry,
  output logic          dup_drop
);
  logic [EW-1:0] last_ent;
  logic          last_vld;
  logic [AW-1:0] last_pc;
  logic          pc_vld;
  logic          raw_valid;
  logic [EW-1:0] raw_entry;

  function automatic logic [EW-1:0] pack_ent(input logic cmp, input logic [AW-1:0] a,
                                             input logic [DW-1:0] d);
    return {cmp, a, d};
  endfunction

  function automatic logic same_page(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return a[AW-1:8] == b[AW-1:8];
  endfunction

  function automatic logic [AW-1:0] low_byte(input logic [AW-1:0] a);
    return {{(AW-8){1'b0}}, a[7:0]};
  endfunction

  always_comb begin
    raw_valid = 1'b0;
    raw_entry = '0;
    unique case (mode)
      TM_FLOW, TM_FILTER: begin
        raw_valid = ev_valid & ev_cof;
        raw_entry = pack_ent(1'b0, ev_pc, '0);
      end
      TM_DETAIL: begin
        raw_valid = mem_valid;
        raw_entry = pack_ent(1'b0, mem_addr, mem_data);
      end
      TM_PCCMP: begin
        raw_valid = ev_valid;
        if (pc_vld && same_page(ev_pc, last_pc))
          raw_entry = pack_ent(1'b1, low_byte(ev_pc), '0);
        else
          raw_entry = pack_ent(1'b0, ev_pc, '0);
      end
      default: ;
    endcase
  end

  assign dup_drop   = (mode == TM_FILTER) & raw_valid & last_vld & (raw_entry == last_ent);
  assign cand_valid = raw_valid & ~dup_drop;
  assign cand_entry = raw_entry;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      last_ent <= '0;
      last_vld <= 1'b0;
      last_pc  <= '0;
      pc_vld   <= 1'b0;
    end else if (commit) begin
      last_ent <= cand_entry;
      last_vld <= 1'b1;
      if (mode == TM_PCCMP) begin
        last_pc <= ev_pc;
        pc_vld  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/trc_cap_fsm.sv
module trc_cap_fsm
  import trc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    armed,
  input  logic    trig,
  input  logic    align,
  input  logic    trace_on,
  input  logic    we,
  input  logic    at_last,
  output logic    arm_rise,
  output logic    cap_open,
  output cap_st_e st
);
  cap_st_e st_q;
  cap_st_e st_d;

  assign arm_rise = armed & (st_q == CS_IDLE);
  assign cap_open = trace_on & ((st_q == CS_HIST) | (st_q == CS_POST) |
                                ((st_q == CS_WAIT) & trig));

  always_comb begin
    st_d = st_q;
    if (!armed) begin
      st_d = CS_IDLE;
    end else begin
      unique case (st_q)
        CS_IDLE: st_d = align ? CS_WAIT : CS_HIST;
        CS_HIST: if (trig) st_d = CS_DONE;
        CS_WAIT: if (trig) st_d = CS_POST;
        CS_POST: if (we && at_last) st_d = CS_DONE;
        CS_DONE: st_d = CS_DONE;
        default: st_d = CS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= CS_IDLE;
    else        st_q <= st_d;
  end

  assign st = st_q;
endmodule

// File: rtl/trc_ring.sv
module trc_ring #(
  parameter  int DEPTH = 64,
  parameter  int EW    = 25,
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          we,
  input  logic [EW-1:0] wdata,
  input  logic          rd_en,
  input  logic [PW-1:0] rd_idx,
  output logic [EW-1:0] rd_data,
  output logic [PW:0]   count,
  output logic          at_last
);
  localparam logic [PW:0] FULL_CNT = (PW+1)'(DEPTH);
  localparam logic [PW:0] LAST_CNT = (PW+1)'(DEPTH - 1);

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr;
  logic [PW:0]   cnt_q;
  logic          full;
  logic [PW-1:0] rd_slot;

  function automatic logic [PW-1:0] oldest_slot(input logic [PW:0] c, input logic [PW-1:0] w);
    return (c == FULL_CNT) ? w : '0;
  endfunction

  assign full    = (cnt_q == FULL_CNT);
  assign at_last = (cnt_q == LAST_CNT);
  assign rd_slot = oldest_slot(cnt_q, wptr) + rd_idx;
  assign rd_data = (rd_en && ({1'b0, rd_idx} < cnt_q)) ? mem[rd_slot] : '0;
  assign count   = cnt_q;

  always_ff @(posedge clk) begin
    if (we) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      wptr  <= '0;
      cnt_q <= '0;
    end else if (we) begin
      wptr <= wptr + 1'b1;
      if (!full) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/trc_capture.sv
module trc_capture
  import trc_pkg::*;
#(
  parameter  int DEPTH = 64,
  parameter  int AW    = 16,
  parameter  int DW    = 8,
  localparam int PW    = $clog2(DEPTH),
  localparam int EW    = 1 + AW + DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          secure,
  input  logic          arm,
  input  logic          trig,
  input  logic          ev_valid,
  input  logic [AW-1:0] ev_pc,
  input  logic          ev_cof,
  input  logic          mem_valid,
  input  logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_data,
  input  logic [PW-1:0] rd_idx,
  output logic [EW-1:0] rd_data,
  output logic [PW:0]   entry_count
);
  logic          src_en;
  trc_mode_e     mode;
  logic          align;
  logic          src_we;
  logic          fld_we;
  logic          trace_on;
  logic          arm_rise;
  logic          cap_open;
  cap_st_e       cap_st;
  logic          cand_valid;
  logic [EW-1:0] cand_entry;
  logic          dup_drop;
  logic          buf_we;
  logic          at_last;

  assign trace_on = src_en & ~secure;
  assign buf_we   = cand_valid & cap_open;

  trc_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata), .secure(secure),
    .armed(arm), .src_en(src_en), .mode(mode), .align(align), .rdata(reg_rdata),
    .src_we(src_we), .fld_we(fld_we)
  );

  trc_entry_sel #(.AW(AW), .DW(DW)) u_sel (
    .clk(clk), .rst_n(rst_n), .clear(arm_rise), .mode(mode), .ev_valid(ev_valid),
    .ev_pc(ev_pc), .ev_cof(ev_cof), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_data(mem_data), .commit(buf_we), .cand_valid(cand_valid),
    .cand_entry(cand_entry), .dup_drop(dup_drop)
  );

  trc_cap_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .armed(arm), .trig(trig), .align(align),
    .trace_on(trace_on), .we(buf_we), .at_last(at_last), .arm_rise(arm_rise),
    .cap_open(cap_open), .st(cap_st)
  );

  trc_ring #(.DEPTH(DEPTH), .EW(EW)) u_ring (
    .clk(clk), .rst_n(rst_n), .clear(arm_rise), .we(buf_we), .wdata(cand_entry),
    .rd_en(src_en), .rd_idx(rd_idx), .rd_data(rd_data), .count(entry_count),
    .at_last(at_last)
  );
endmodule

// File: rtl/trc_capture_chk.sv
module trc_capture_chk
  import trc_pkg::*;
#(
  parameter  int DEPTH = 64,
  parameter  int EW    = 25,
  localparam int PW    = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arm,
  input logic          secure,
  input logic          trig,
  input logic [7:0]    reg_rdata,
  input logic [PW:0]   entry_count,
  input logic [EW-1:0] rd_data,
  input cap_st_e       st,
  input logic          buf_we,
  input logic          arm_rise
);
  localparam logic [PW:0] FULL_CNT = (PW+1)'(DEPTH);

  a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    entry_count <= FULL_CNT);

  a_r3_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> $stable(reg_rdata[3:0]));

  a_r10_no_store_secure: assert property (@(posedge clk) disable iff (!rst_n)
    secure |-> !buf_we);

  a_r10_enable_locked: assert property (@(posedge clk) disable iff (!rst_n)
    secure |=> !$rose(reg_rdata[6]));

  a_r9_quiet_before_trig: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CS_WAIT && !trig) |-> !buf_we);

  a_r8_stop_on_trig: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CS_HIST && trig) |=> (st != CS_HIST && !buf_we));

  a_r11_locked_read: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[6] |-> (rd_data == '0));

  a_r12_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    arm_rise |=> (entry_count == '0));
endmodule

bind trc_capture trc_capture_chk #(.DEPTH(DEPTH), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .secure(secure), .trig(trig),
  .reg_rdata(reg_rdata), .entry_count(entry_count), .rd_data(rd_data),
  .st(cap_st), .buf_we(buf_we), .arm_rise(arm_rise)
);

// File: tb/trc_capture_bench.sv
module trc_capture_bench;
  localparam int DEPTH = 64;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int PW = 6;
  localparam int EW = 1 + AW + DW;

  // {secure, arm, write value, expected read-back}
  localparam logic [17:0] REGV [7] = '{
    {1'b0, 1'b0, 8'hFF, 8'h4D},
    {1'b0, 1'b0, 8'h00, 8'h00},
    {1'b1, 1'b0, 8'h4D, 8'h0D},
    {1'b0, 1'b1, 8'h41, 8'h0D},
    {1'b0, 1'b0, 8'h45, 8'h45},
    {1'b1, 1'b0, 8'h00, 8'h40},
    {1'b0, 1'b1, 8'h08, 8'h40}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic secure = 1'b0, arm = 1'b0, trig = 1'b0;
  logic ev_valid = 1'b0, ev_cof = 1'b0, mem_valid = 1'b0;
  logic [AW-1:0] ev_pc = '0, mem_addr = '0;
  logic [DW-1:0] mem_data = '0;
  logic [PW-1:0] rd_idx = '0;
  logic [EW-1:0] rd_data;
  logic [PW:0] entry_count;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  trc_capture u_trc_capture (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .secure(secure), .arm(arm), .trig(trig),
    .ev_valid(ev_valid), .ev_pc(ev_pc), .ev_cof(ev_cof), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_data(mem_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .entry_count(entry_count)
  );

  function automatic logic [31:0] ent(input logic f, input logic [AW-1:0] a,
                                      input logic [DW-1:0] d);
    return 32'({f, a, d});
  endfunction

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_rd(input string tag, input int idx, input logic [31:0] exp);
    rd_idx = PW'(idx);
    #1;
    chk(tag, 32'(rd_data), exp);
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    reg_wr = 1'b1; reg_wdata = v; tick(); reg_wr = 1'b0;
  endtask

  task automatic ev(input logic [AW-1:0] pc, input logic cof, input logic tg);
    ev_valid = 1'b1; ev_pc = pc; ev_cof = cof; trig = tg;
    tick();
    ev_valid = 1'b0; ev_cof = 1'b0; trig = 1'b0;
  endtask

  task automatic macc(input logic [AW-1:0] a, input logic [DW-1:0] d);
    mem_valid = 1'b1; mem_addr = a; mem_data = d; tick(); mem_valid = 1'b0;
  endtask

  task automatic rearm(input logic [7:0] v);
    arm = 1'b0; tick(); wr_ctl(v); arm = 1'b1; tick();
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    tick(); tick(); rst_n = 1'b1; tick();
    // R1 reset state
    chk("R1 ctl", 32'(reg_rdata), 32'h0);
    chk("R1 count", 32'(entry_count), 32'h0);
    chk_rd("R1 rd", 0, 32'h0);

    // R2 R3: write gating table
    for (int k = 0; k < 7; k++) begin
      secure = REGV[k][17]; arm = REGV[k][16];
      wr_ctl(REGV[k][15:8]);
      chk($sformatf("R2 R3 row%0d", k), 32'(reg_rdata), 32'(REGV[k][7:0]));
      secure = 1'b0; arm = 1'b0; tick();
    end

    // R4 flow policy, end aligned; trigger shares a cycle with an event (R8)
    rearm(8'h40);
    ev(16'h1000, 1'b0, 1'b0);
    ev(16'h1234, 1'b1, 1'b0);
    ev(16'h1236, 1'b0, 1'b0);
    ev(16'h2000, 1'b1, 1'b0);
    macc(16'h0040, 8'h11);
    ev(16'h3000, 1'b1, 1'b1);
    ev(16'h4000, 1'b1, 1'b0);
    chk("R4 count", 32'(entry_count), 32'd3);
    chk_rd("R4 first", 0, ent(1'b0, 16'h1234, 8'h00));
    chk_rd("R8 trig entry", 2, ent(1'b0, 16'h3000, 8'h00));
    chk_rd("R11 beyond count", 3, 32'h0);

    // R5 repeat filter; R12 rearm cleared history
    rearm(8'h44);
    chk("R12 cleared", 32'(entry_count), 32'd0);
    ev(16'h0100, 1'b1, 1'b0);
    ev(16'h0100, 1'b1, 1'b0);
    ev(16'h0200, 1'b1, 1'b0);
    ev(16'h0100, 1'b1, 1'b0);
    ev(16'h0100, 1'b1, 1'b0);
    chk("R5 count", 32'(entry_count), 32'd3);
    chk_rd("R5 last", 2, ent(1'b0, 16'h0100, 8'h00));

    // R6 access detail, repeats kept, instruction events ignored
    rearm(8'h48);
    macc(16'h0010, 8'hAA);
    ev(16'h0050, 1'b1, 1'b0);
    macc(16'h0020, 8'hBB);
    macc(16'h0020, 8'hBB);
    chk("R6 count", 32'(entry_count), 32'd3);
    chk_rd("R6 entry", 1, ent(1'b0, 16'h0020, 8'hBB));
    chk_rd("R13 layout", 0, 32'h0010AA);

    // R7 compact counter
    rearm(8'h4C);
    ev(16'h1200, 1'b0, 1'b0);
    ev(16'h1201, 1'b1, 1'b0);
    ev(16'h1305, 1'b0, 1'b0);
    ev(16'h1306, 1'b0, 1'b0);
    chk("R7 count", 32'(entry_count), 32'd4);
    chk_rd("R7 full", 0, ent(1'b0, 16'h1200, 8'h00));
    chk_rd("R7 short", 1, ent(1'b1, 16'h0001, 8'h00));
    chk_rd("R7 page change", 2, ent(1'b0, 16'h1305, 8'h00));
    chk_rd("R7 short2", 3, ent(1'b1, 16'h0006, 8'h00));

    // R8 wrap before trigger
    rearm(8'h40);
    for (int i = 0; i < DEPTH + 6; i++) ev(AW'(16'h0800 + i), 1'b1, 1'b0);
    trig = 1'b1; tick(); trig = 1'b0;
    ev(16'h0F00, 1'b1, 1'b0);
    chk("R8 saturate", 32'(entry_count), 32'd64);
    chk_rd("R8 oldest", 0, ent(1'b0, 16'h0806, 8'h00));
    chk_rd("R8 newest", DEPTH - 1, ent(1'b0, 16'h0845, 8'h00));

    // R9 start aligned
    rearm(8'h41);
    for (int i = 0; i < 5; i++) ev(AW'(16'h0300 + i), 1'b1, 1'b0);
    chk("R9 pre-trigger", 32'(entry_count), 32'd0);
    ev(16'h0500, 1'b1, 1'b1);
    chk("R9 trig event", 32'(entry_count), 32'd1);
    for (int i = 1; i <= DEPTH + 6; i++) ev(AW'(16'h0500 + i), 1'b1, 1'b0);
    chk("R9 stop full", 32'(entry_count), 32'd64);
    chk_rd("R9 newest", DEPTH - 1, ent(1'b0, 16'h053F, 8'h00));
    arm = 1'b0; tick();
    chk_rd("R12 kept after disarm", 0, ent(1'b0, 16'h0500, 8'h00));

    // R11 read locked with enable clear
    wr_ctl(8'h01);
    chk_rd("R11 locked", 0, 32'h0);
    chk("R11 count kept", 32'(entry_count), 32'd64);

    // R10 secure inhibits storing
    wr_ctl(8'h40);
    secure = 1'b1; arm = 1'b1; tick();
    ev(16'h0700, 1'b1, 1'b0);
    ev(16'h0702, 1'b1, 1'b0);
    chk("R10 no store", 32'(entry_count), 32'd0);
    chk("R10 enable kept", 32'(reg_rdata), 32'h40);
    arm = 1'b0; secure = 1'b0; tick();

    finish_run();
  end
endmodule